// File: doc/BRIEF.md
# Low-Speed USB Packet Serialiser

This block sends one packet onto the D+/D- wire pair at the low-speed bit rate. A caller loads the packet payload into a small external buffer and then pulses `start` with the total byte count. That count includes the sync byte, which the block produces itself. The block first takes the bus. It then shifts out the sync byte and every payload byte LSB first, with NRZI line coding and bit stuffing. It ends the packet with an SE0 end-of-packet, a short idle J, and the release of the output enable. Payload bytes are fetched one byte ahead through a simple read port with a one-cycle read latency.

Control is a single state machine with six states. `S_IDLE` holds the lines at J with the enable off. A valid start moves it to `S_PREP`, which lasts one bit period with J prepared and the enable still off. `S_ACQ` drives J with the enable on for one bit period. `S_SEND` emits the data and stuff bits. Once the last bit and any stuff bit owed after it have gone out, it moves to `S_EOP`, which holds SE0 for two bit periods. `S_JIDLE` drives J for one bit period and then returns to `S_IDLE`, where the enable drops. Every move happens on a bit tick, except the move out of `S_IDLE`, which happens on the accepted start.

An address update that the caller has left pending is reported as committed only when the data packet has finished. This is signalled as a pulse at the start of the end-of-packet.

Top module: `usb_ls_tx`

## Requirements
- R1: After a start is accepted, the block holds J (dp=0, dm=1) with oe=0 for one bit period. It then holds J with oe=1 for one more bit period before the first sync bit.
- R2: The first byte sent is the sync byte 0x80, LSB first, so the line reads K J K J K J K K after the idle J.
- R3: A start is taken only while busy is low and 2 <= byte_count <= MAX_BYTES (12). A start outside that range, or a start while busy, has no effect.
- R4: The line uses NRZI coding. A 0 bit toggles the line between J (dp=0, dm=1) and K (dp=1, dm=0), and a 1 bit keeps the line unchanged.
- R5: After six consecutive 1 bits, one extra toggle is inserted. This applies at any bit position, including across byte boundaries and after the final bit of the final byte. The run counter clears on every toggle, including the inserted one, and it is zero at the start of the sync byte.
- R6: Payload bytes are read in order from buffer index 0 to byte_count-2. Each read is one rd_en pulse, and rd_data is taken the cycle after it.
- R7: After the last bit, including any stuff bit that follows it, the block drives SE0 (dp=0, dm=0) for two bit periods. It then drives J for one bit period and then drops oe.
- R8: busy is high from the cycle after the accepted start until oe is released. done is high for exactly one cycle, the first cycle after release.
- R9: addr_commit pulses once, in the first SE0 cycle, when addr_pend is high at that point, and never otherwise.
- R10: Every bit period lasts CLKS_PER_BIT clocks. oe is therefore high for (data bits + stuff bits + 4) * CLKS_PER_BIT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for a packet |
| byte_count | input | 4 | Number of bytes including sync, 2..12 |
| addr_pend | input | 1 | An address change waits for this packet |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | 4 | Buffer read index |
| rd_data | input | 8 | Buffer read data, valid the cycle after rd_en |
| dp | output | 1 | D+ line level |
| dm | output | 1 | D- line level |
| oe | output | 1 | Line driver enable |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse after release |
| addr_commit | output | 1 | Pending address may now take effect |

## Verification
The accepted start registers the state on edge E0. Line slot s then covers the cycles from E0 + s*CLKS_PER_BIT up to the next slot boundary: the prepare slot, the acquire slot, one slot per data or stuff bit, two SE0 slots, one J slot, and then the released slot. The monitor samples each slot half a bit period after its boundary, at a falling edge, so a line change that lands on a tick edge can never be confused with its neighbour. The done pulse, the commit pulse, the number of reads and the enable-high cycle count are collected by counters on falling edges. They are compared two cycles after the last slot has been checked.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_ACQ,
        S_SEND,
        S_EOP,
        S_JIDLE
    } tx_state_e;

    localparam logic [7:0] SYNC_PATTERN = 8'h80;
    localparam int         RUN_LIMIT    = 6;

endpackage

// File: rtl/usb_ls_tx_baud.sv
module usb_ls_tx_baud #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int                CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(CLKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/usb_ls_tx_nrzi.sv
module usb_ls_tx_nrzi
    import usb_ls_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_run,
    input  logic step,
    input  logic bit_in,
    input  logic go_se0,
    input  logic go_j,
    output logic stuff_due,
    output logic dp,
    output logic dm
);
    logic       lvl_q;
    logic       se0_q;
    logic [2:0] ones_q;

    assign stuff_due = (ones_q == 3'(RUN_LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= 1'b1;
            se0_q  <= 1'b0;
            ones_q <= '0;
        end else begin
            if (go_j) begin
                lvl_q <= 1'b1;
                se0_q <= 1'b0;
            end else if (go_se0) begin
                se0_q <= 1'b1;
            end else if (step) begin
                if (stuff_due || !bit_in) begin
                    lvl_q  <= ~lvl_q;
                    ones_q <= '0;
                end else begin
                    ones_q <= ones_q + 3'd1;
                end
            end
            if (clr_run) begin
                ones_q <= '0;
            end
        end
    end

    assign dp = ~se0_q & ~lvl_q;
    assign dm = ~se0_q &  lvl_q;

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
    import usb_ls_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int MAX_BYTES    = 12,
    localparam int CW          = $clog2(MAX_BYTES + 1),
    localparam int AW          = $clog2(MAX_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] byte_count,
    input  logic          addr_pend,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          dp,
    output logic          dm,
    output logic          oe,
    output logic          busy,
    output logic          done,
    output logic          addr_commit
);
    tx_state_e     state_q, state_d;
    logic          tick;
    logic          stuff_due;
    logic          start_ok;
    logic          emit;
    logic          consume;
    logic          go_se0;
    logic          go_j;
    logic [7:0]    sh_q;
    logic [7:0]    nxt_q;
    logic [2:0]    bi_q;
    logic [CW-1:0] rem_q;
    logic          rd_pend_q;
    logic          all_sent_q;
    logic          eop_half_q;

    assign start_ok = start
                   && (byte_count >= CW'(2))
                   && (byte_count <= CW'(MAX_BYTES));

    usb_ls_tx_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != S_IDLE),
        .tick  (tick)
    );

    assign go_se0  = tick && (state_q == S_SEND) && all_sent_q && !stuff_due;
    assign go_j    = tick && (state_q == S_EOP) && eop_half_q;
    assign emit    = tick && ((state_q == S_ACQ) ||
                              ((state_q == S_SEND) && !(all_sent_q && !stuff_due)));
    assign consume = emit && !stuff_due && !all_sent_q;

    usb_ls_tx_nrzi u_nrzi (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_run   (state_q == S_IDLE),
        .step      (emit),
        .bit_in    (sh_q[0]),
        .go_se0    (go_se0),
        .go_j      (go_j),
        .stuff_due (stuff_due),
        .dp        (dp),
        .dm        (dm)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_ok)               state_d = S_PREP;
            S_PREP:  if (tick)                   state_d = S_ACQ;
            S_ACQ:   if (tick)                   state_d = S_SEND;
            S_SEND:  if (go_se0)                 state_d = S_EOP;
            S_EOP:   if (go_j)                   state_d = S_JIDLE;
            S_JIDLE: if (tick)                   state_d = S_IDLE;
            default:                             state_d = S_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        oe   = 1'b0;
        busy = 1'b1;
        unique case (state_q)
            S_IDLE:  busy = 1'b0;
            S_PREP:  oe   = 1'b0;
            S_ACQ,
            S_SEND,
            S_EOP,
            S_JIDLE: oe   = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // Byte path, prefetch and pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q        <= '0;
            nxt_q       <= '0;
            bi_q        <= '0;
            rem_q       <= '0;
            rd_en       <= 1'b0;
            rd_addr     <= '0;
            rd_pend_q   <= 1'b0;
            all_sent_q  <= 1'b0;
            eop_half_q  <= 1'b0;
            done        <= 1'b0;
            addr_commit <= 1'b0;
        end else begin
            rd_en       <= 1'b0;
            done        <= 1'b0;
            addr_commit <= 1'b0;
            rd_pend_q   <= rd_en;
            if (rd_pend_q) begin
                nxt_q <= rd_data;
            end
            if (state_q == S_IDLE && start_ok) begin
                sh_q       <= SYNC_PATTERN;
                bi_q       <= '0;
                rem_q      <= byte_count - CW'(1);
                all_sent_q <= 1'b0;
                eop_half_q <= 1'b0;
                rd_en      <= 1'b1;
                rd_addr    <= '0;
            end
            if (consume) begin
                sh_q <= {1'b0, sh_q[7:1]};
                bi_q <= bi_q + 3'd1;
                if (bi_q == 3'd7) begin
                    if (rem_q == '0) begin
                        all_sent_q <= 1'b1;
                    end else begin
                        sh_q  <= nxt_q;
                        rem_q <= rem_q - CW'(1);
                        if (rem_q > CW'(1)) begin
                            rd_en   <= 1'b1;
                            rd_addr <= rd_addr + AW'(1);
                        end
                    end
                end
            end
            if (go_se0) begin
                addr_commit <= addr_pend;
            end
            if (tick && state_q == S_EOP) begin
                eop_half_q <= 1'b1;
            end
            if (tick && state_q == S_JIDLE) begin
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk #(
    parameter int MAX_BYTES = 12,
    localparam int CW       = $clog2(MAX_BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [CW-1:0] byte_count,
    input logic          dp,
    input logic          dm,
    input logic          oe,
    input logic          busy,
    input logic          done,
    input logic          rd_en,
    input logic          addr_commit
);
    p_j_before_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> (dm && !dp && $past(dm && !dp)));

    p_bad_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (byte_count < CW'(2) || byte_count > CW'(MAX_BYTES))) |=> !busy);

    p_idle_is_j_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (dm && !dp));

    p_read_in_packet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    p_se0_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dp && !dm) |-> oe);

    p_release_from_j_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> (dm && !dp && $past(dm && !dp)));

    p_oe_inside_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> busy);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!oe && !busy));

    p_commit_at_se0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_commit |-> (oe && !dp && !dm));

endmodule

bind usb_ls_tx usb_ls_tx_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .byte_count  (byte_count),
    .dp          (dp),
    .dm          (dm),
    .oe          (oe),
    .busy        (busy),
    .done        (done),
    .rd_en       (rd_en),
    .addr_commit (addr_commit)
);

// File: tb/usb_ls_tx_tb.sv
module usb_ls_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] byte_count = '0;
    logic       addr_pend = 1'b0;
    logic       rd_en;
    logic [3:0] rd_addr;
    logic [7:0] rd_data = '0;
    logic       dp, dm, oe, busy, done, addr_commit;

    logic [7:0] mem [16];
    logic [2:0] qv [$];
    string      qt [$];
    int checks = 0;
    int errors = 0;
    int done_cnt = 0, com_cnt = 0, rd_cnt = 0, rd_exp = 0, oe_cnt = 0;
    bit mon_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_ls_tx #(.CLKS_PER_BIT(CPB), .MAX_BYTES(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .addr_pend(addr_pend), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .dp(dp), .dm(dm), .oe(oe), .busy(busy), .done(done), .addr_commit(addr_commit)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Buffer model: one-cycle read latency
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    // Event counters sampled away from the active edge
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (addr_commit) com_cnt++;
        if (oe) oe_cnt++;
        if (rd_en) begin
            chk(rd_addr == 4'(rd_exp), "R6", "read index", int'(rd_addr), rd_exp);
            rd_cnt++;
            rd_exp++;
        end
    end

    // Monitor: one sample per bit slot, half a bit after the boundary
    initial begin
        forever begin
            @(negedge clk);
            if (busy && qv.size() > 0) begin
                mon_busy = 1;
                repeat (CPB/2) @(negedge clk);
                while (qv.size() > 0) begin
                    automatic logic [2:0] v = qv.pop_front();
                    automatic string t = qt.pop_front();
                    chk({oe, dp, dm} == v, t, "line {oe,dp,dm}", int'({oe, dp, dm}), int'(v));
                    if (qv.size() > 0) repeat (CPB) @(negedge clk);
                end
                mon_busy = 0;
            end
        end
    end

    task automatic push(input logic [2:0] v, input string t);
        qv.push_back(v);
        qt.push_back(t);
    endtask

    // Driver: builds the expected slot stream, then starts the packet
    task automatic run_pkt(input int cnt, input logic pend, input bit poke);
        int  exp_oe;
        int  d0, c0;
        logic lvl = 1'b1;
        int  ones = 0;
        push(3'b001, "R1");
        push(3'b101, "R1");
        for (int i = 0; i < cnt; i++) begin
            logic [7:0] b = (i == 0) ? 8'h80 : mem[i-1];
            for (int k = 0; k < 8; k++) begin
                if (!b[k]) begin lvl = ~lvl; ones = 0; end
                else ones++;
                push({1'b1, ~lvl, lvl}, (i == 0) ? "R2" : "R4");
                if (ones == 6) begin
                    lvl = ~lvl; ones = 0;
                    push({1'b1, ~lvl, lvl}, "R5");
                end
            end
        end
        push(3'b100, "R7");
        push(3'b100, "R7");
        push(3'b101, "R7");
        push(3'b001, "R7");
        exp_oe = (qv.size() - 2) * CPB;
        d0 = done_cnt; c0 = com_cnt; rd_cnt = 0; rd_exp = 0; oe_cnt = 0;
        @(negedge clk);
        byte_count = 4'(cnt); addr_pend = pend; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5*CPB) @(negedge clk);
            byte_count = 4'd2; start = 1'b1;   // R3: start while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (qv.size() != 0 || mon_busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(done_cnt - d0 == 1, "R8", "done pulses", done_cnt - d0, 1);
        chk(!busy, "R8", "busy after release", int'(busy), 0);
        chk(com_cnt - c0 == int'(pend), "R9", "addr_commit pulses", com_cnt - c0, int'(pend));
        chk(rd_cnt == cnt - 1, "R6", "reads", rd_cnt, cnt - 1);
        chk(oe_cnt == exp_oe, "R10", "oe-high cycles", oe_cnt, exp_oe);
        addr_pend = 1'b0;
    endtask

    task automatic bad_start(input int cnt);
        @(negedge clk);
        byte_count = 4'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !oe, "R3", "rejected count leaves block idle", int'({busy, oe}), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!oe && !busy && !done, "R8", "reset outputs", int'({oe, busy, done}), 0);
        chk(!dp && dm, "R4", "reset line J", int'({dp, dm}), 1);

        bad_start(1);
        bad_start(13);
        bad_start(0);

        mem[0] = 8'hC3; mem[1] = 8'h5A;
        run_pkt(3, 1'b0, 1'b1);

        mem[0] = 8'hFC;                      // R5: stuff after last bit
        run_pkt(2, 1'b1, 1'b0);

        for (int i = 0; i < 11; i++) mem[i] = 8'hFF;
        run_pkt(12, 1'b0, 1'b0);

        mem[0] = 8'h01; mem[1] = 8'h80; mem[2] = 8'h7F;
        run_pkt(4, 1'b1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule